// File: doc/BRIEF.md
# Audio Serial Clock Prescaler

This block derives the three clocks an audio serial-bus master drives from a single system clock. A prescaler divides the system clock by an effective ratio N, which is twice an 8-bit linear value plus one odd-adjust bit. N may be odd. With the master clock output off, the prescaled clock is used directly as the serial bit clock. With the master clock output on, the prescaled clock leaves the block as the master clock, and a second divider (by 8 for 16-bit channels, by 4 for 32-bit channels) produces the bit clock. In that case the frame is always 256·N system clocks long.

A word-select output alternates between the left channel (low) and the right channel (high) every 16 or 32 bit periods. Two single-cycle strobes are provided for a serializer: one at the start of every bit period and one at the start of every frame. All configuration is loaded while the enable is low and must stay constant while it is high. Raising the enable starts the clocks from a defined phase. Every output is registered.

Top module: `aclk_gen`

## Requirements
- R1: The effective ratio is N = 2·L + odd_adj, where L is the linear value after clamping. When mclk_oe is 1, mclk_o is periodic with period N system clocks: it is low for floor(N/2) cycles and then high for the remaining cycles.
- R2: With mclk_oe = 0 and long_ch = 0 (16-bit channels), the bit period is N cycles and frame_stb recurs every 32·N cycles.
- R3: With mclk_oe = 0 and long_ch = 1 (32-bit channels), the bit period is N cycles and frame_stb recurs every 64·N cycles.
- R4: With mclk_oe = 1, the bit period is 8·N cycles for 16-bit channels and 4·N cycles for 32-bit channels. In both cases frame_stb recurs every 256·N cycles.
- R5: While mclk_oe = 0, mclk_o stays low.
- R6: While the block is not running, ck_o rests at idle_pol. Each bit period starts with ck_o at idle_pol for floor(B/2) cycles, where B is the bit period, and ck_o is at the inverse level for the rest of the period.
- R7: A lin_div value of 0 or 1 acts as 2, so N is 4 or 5.
- R8: ws_o is low for the first 16 (or 32) bit periods after the start and then toggles at every 16th (or 32nd) bit boundary. It changes only in a cycle that carries shift_stb.
- R9: shift_stb is a one-cycle pulse in the first cycle of every bit period. frame_stb is a one-cycle pulse coincident with the shift_stb that starts bit 0 of a left-channel word (ws_o low).
- R10: When en is low, all counters clear. From the second clock edge after en is first sampled low, the outputs are idle: ws_o, mclk_o and both strobes are low. After en is sampled high at an edge, the first shift_stb and frame_stb appear in the output register at the following edge. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; configuration must be stable while high |
| lin_div | input | 8 | Linear divide value L (values below 2 act as 2) |
| odd_adj | input | 1 | Adds one to the effective ratio |
| mclk_oe | input | 1 | Master clock output enable; selects the two-stage divide chain |
| long_ch | input | 1 | Channel length: 0 = 16 bits, 1 = 32 bits |
| idle_pol | input | 1 | Resting level of the bit clock |
| mclk_o | output | 1 | Master clock, period N |
| ck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select, low for the left channel |
| shift_stb | output | 1 | One-cycle pulse at the start of each bit period |
| frame_stb | output | 1 | One-cycle pulse at the start of each frame |

## Verification
The bench uses the default parameters: an 8-bit divider, 16- and 32-bit channel lengths, master-clock sub-divides of 8 and 4, and the master-clock path present. This makes both divide chains reachable, along with odd and even ratios, the clamp of small linear values and both idle polarities. Frame lengths from 160 to 2304 cycles keep several complete frames per configuration inside the run. A behavioural model that works from elapsed cycles predicts every output on every cycle, and measured frame periods and start latency are checked against the formulas.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

   // Smallest linear divide value honoured; lower settings are raised to it.
   localparam int MIN_LIN = 2;

   typedef struct packed {
      logic mclk;
      logic ck;
      logic ws;
      logic shift;
      logic frame;
   } aclk_out_t;

endpackage

// File: rtl/aclk_prediv.sv
// First stage: counts 0..N-1 with N = 2*max(L,2) + odd.
module aclk_prediv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [DIV_W-1:0] lin,
   input  logic             odd,
   output logic             wrap,
   output logic             at_zero,
   output logic             phase_hi
);
   localparam int RAT_W = DIV_W + 1;

   logic [DIV_W-1:0] lin_eff;
   logic [RAT_W-1:0] ratio;
   logic [RAT_W-1:0] cnt_q;
   logic             last;

   assign lin_eff = (lin < DIV_W'(aclk_pkg::MIN_LIN)) ? DIV_W'(aclk_pkg::MIN_LIN) : lin;
   // Concatenation gives 2*lin_eff + odd; floor(ratio/2) equals lin_eff.
   assign ratio   = {lin_eff, odd};
   assign last    = (cnt_q == ratio - RAT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!go)    cnt_q <= '0;
      else if (last)   cnt_q <= '0;
      else             cnt_q <= cnt_q + RAT_W'(1);
   end

   assign wrap     = go & last;
   assign at_zero  = (cnt_q == '0);
   assign phase_hi = (cnt_q >= {1'b0, lin_eff});
endmodule

// File: rtl/aclk_subdiv.sv
// Second stage: optional master-clock path that divides the prescaled clock
// down to the bit clock; bypassed when the master clock output is off.
module aclk_subdiv #(
   parameter int SHORT_MDIV = 8,
   parameter int LONG_MDIV  = 4,
   parameter bit HAS_MCLK   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic mclk_oe,
   input  logic long_ch,
   input  logic pre_wrap,
   input  logic pre_zero,
   input  logic pre_hi,
   output logic bit_wrap,
   output logic bit_zero,
   output logic bit_hi,
   output logic mclk_lvl
);
   localparam int MAX_MDIV = (SHORT_MDIV > LONG_MDIV) ? SHORT_MDIV : LONG_MDIV;
   localparam int MC_W     = $clog2(MAX_MDIV);

   generate
      if (HAS_MCLK) begin : g_mpath
         localparam logic [MC_W-1:0] S_LAST = MC_W'(SHORT_MDIV - 1);
         localparam logic [MC_W-1:0] L_LAST = MC_W'(LONG_MDIV - 1);
         localparam logic [MC_W-1:0] S_HALF = MC_W'(SHORT_MDIV / 2);
         localparam logic [MC_W-1:0] L_HALF = MC_W'(LONG_MDIV / 2);

         logic [MC_W-1:0] mc_q;
         logic [MC_W-1:0] mc_last;
         logic [MC_W-1:0] mc_half;
         logic            mc_end;

         assign mc_last = long_ch ? L_LAST : S_LAST;
         assign mc_half = long_ch ? L_HALF : S_HALF;
         assign mc_end  = (mc_q == mc_last);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      mc_q <= '0;
            else if (!go)                    mc_q <= '0;
            else if (pre_wrap && mclk_oe)    mc_q <= mc_end ? '0 : mc_q + MC_W'(1);
         end

         assign bit_wrap = mclk_oe ? (pre_wrap & mc_end) : pre_wrap;
         assign bit_zero = pre_zero & (~mclk_oe | (mc_q == '0));
         assign bit_hi   = mclk_oe ? (mc_q >= mc_half) : pre_hi;
         assign mclk_lvl = mclk_oe & pre_hi;
      end else begin : g_nompath
         logic unused_cfg;
         assign unused_cfg = mclk_oe ^ long_ch ^ clk ^ rst_n ^ go;
         assign bit_wrap   = pre_wrap;
         assign bit_zero   = pre_zero;
         assign bit_hi     = pre_hi;
         assign mclk_lvl   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/aclk_frame.sv
// Bit counter within a channel word and word-select toggle.
module aclk_frame #(
   parameter int SHORT_BITS = 16,
   parameter int LONG_BITS  = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic long_ch,
   input  logic bit_wrap,
   output logic ws_q,
   output logic bc_zero
);
   localparam int MAX_BITS = (SHORT_BITS > LONG_BITS) ? SHORT_BITS : LONG_BITS;
   localparam int BC_W     = $clog2(MAX_BITS);
   localparam logic [BC_W-1:0] S_LAST = BC_W'(SHORT_BITS - 1);
   localparam logic [BC_W-1:0] L_LAST = BC_W'(LONG_BITS - 1);

   logic [BC_W-1:0] bc_q;
   logic            bc_end;

   assign bc_end = (bc_q == (long_ch ? L_LAST : S_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bc_q <= '0;
         ws_q <= 1'b0;
      end else if (!go) begin
         bc_q <= '0;
         ws_q <= 1'b0;
      end else if (bit_wrap) begin
         if (bc_end) begin
            bc_q <= '0;
            ws_q <= ~ws_q;
         end else begin
            bc_q <= bc_q + BC_W'(1);
         end
      end
   end

   assign bc_zero = (bc_q == '0);
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen #(
   parameter int DIV_W      = 8,
   parameter int SHORT_BITS = 16,
   parameter int LONG_BITS  = 32,
   parameter int SHORT_MDIV = 8,
   parameter int LONG_MDIV  = 4,
   parameter bit HAS_MCLK   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] lin_div,
   input  logic             odd_adj,
   input  logic             mclk_oe,
   input  logic             long_ch,
   input  logic             idle_pol,
   output logic             mclk_o,
   output logic             ck_o,
   output logic             ws_o,
   output logic             shift_stb,
   output logic             frame_stb
);
   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("aclk_gen: DIV_W must be at least 2");
      end
      if (SHORT_MDIV < 2 || LONG_MDIV < 2 || (SHORT_MDIV % 2) != 0 || (LONG_MDIV % 2) != 0) begin : g_bad_mdiv
         $error("aclk_gen: master-clock sub-divides must be even and at least 2");
      end
      if (SHORT_BITS * SHORT_MDIV != LONG_BITS * LONG_MDIV) begin : g_bad_frame
         $error("aclk_gen: master-clock frame length must not depend on channel length");
      end
   endgenerate

   logic run_q, go;
   logic pre_wrap, pre_zero, pre_hi;
   logic bit_wrap, bit_zero, bit_hi, mclk_lvl;
   logic ws_q, bc_zero;
   aclk_pkg::aclk_out_t out_d, out_q;

   // One idle edge after enable lets all counters start from zero together.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= en;
   end
   assign go = run_q & en;

   aclk_prediv #(.DIV_W(DIV_W)) i_prediv (
      .clk(clk), .rst_n(rst_n), .go(go), .lin(lin_div), .odd(odd_adj),
      .wrap(pre_wrap), .at_zero(pre_zero), .phase_hi(pre_hi)
   );

   aclk_subdiv #(.SHORT_MDIV(SHORT_MDIV), .LONG_MDIV(LONG_MDIV), .HAS_MCLK(HAS_MCLK)) i_subdiv (
      .clk(clk), .rst_n(rst_n), .go(go), .mclk_oe(mclk_oe), .long_ch(long_ch),
      .pre_wrap(pre_wrap), .pre_zero(pre_zero), .pre_hi(pre_hi),
      .bit_wrap(bit_wrap), .bit_zero(bit_zero), .bit_hi(bit_hi), .mclk_lvl(mclk_lvl)
   );

   aclk_frame #(.SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS)) i_frame (
      .clk(clk), .rst_n(rst_n), .go(go), .long_ch(long_ch), .bit_wrap(bit_wrap),
      .ws_q(ws_q), .bc_zero(bc_zero)
   );

   always_comb begin
      out_d.mclk  = run_q & mclk_lvl;
      out_d.ck    = run_q ? (bit_hi ^ idle_pol) : idle_pol;
      out_d.ws    = run_q & ws_q;
      out_d.shift = run_q & bit_zero;
      out_d.frame = run_q & bit_zero & bc_zero & ~ws_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= out_d;
   end

   assign mclk_o    = out_q.mclk;
   assign ck_o      = out_q.ck;
   assign ws_o      = out_q.ws;
   assign shift_stb = out_q.shift;
   assign frame_stb = out_q.frame;
endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic mclk_oe,
   input logic idle_pol,
   input logic mclk_o,
   input logic ck_o,
   input logic ws_o,
   input logic shift_stb,
   input logic frame_stb
);
   assert_mclk_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mclk_oe && !$past(mclk_oe)) |-> !mclk_o);

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(en, 2) && !$past(en)) |-> (!ws_o && !shift_stb && !frame_stb && !mclk_o));

   assert_frame_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |-> (shift_stb && !ws_o));

   assert_shift_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      shift_stb |=> !shift_stb);

   assert_ws_on_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en, 2) && (ws_o != $past(ws_o))) |-> shift_stb);

   assert_ck_idle_at_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
      shift_stb |-> (ck_o == idle_pol));
endmodule

bind aclk_gen aclk_gen_chk i_aclk_gen_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .mclk_oe(mclk_oe), .idle_pol(idle_pol),
   .mclk_o(mclk_o), .ck_o(ck_o), .ws_o(ws_o), .shift_stb(shift_stb), .frame_stb(frame_stb)
);

// File: tb/test_aclk_gen.sv
module test_aclk_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, odd_adj = 1'b0, mclk_oe = 1'b0, long_ch = 1'b0, idle_pol = 1'b0;
   logic [7:0] lin_div = 8'd2;
   logic mclk_o, ck_o, ws_o, shift_stb, frame_stb;

   always #4 clk = ~clk;

   aclk_gen i_aclk_gen (
      .clk(clk), .rst_n(rst_n), .en(en), .lin_div(lin_div), .odd_adj(odd_adj),
      .mclk_oe(mclk_oe), .long_ch(long_ch), .idle_pol(idle_pol),
      .mclk_o(mclk_o), .ck_o(ck_o), .ws_o(ws_o), .shift_stb(shift_stb), .frame_stb(frame_stb)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: expected outputs from elapsed cycles since start.
   int m_e = 0;
   bit m_run = 1'b0;
   bit x_mclk, x_ck, x_ws, x_sh, x_fr;
   bit cmp_on = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 1'b0; m_e = 0;
         x_mclk = 0; x_ck = 0; x_ws = 0; x_sh = 0; x_fr = 0;
      end else begin
         if (m_run) begin
            int l, n, w, b, q, bi;
            l  = (lin_div < 2) ? 2 : int'(lin_div);
            n  = 2 * l + int'(odd_adj);
            w  = long_ch ? 32 : 16;
            b  = mclk_oe ? n * (long_ch ? 4 : 8) : n;
            q  = m_e % b;
            bi = m_e / b;
            x_mclk = mclk_oe && ((m_e % n) >= n / 2);
            x_ck   = (q >= b / 2) ^ idle_pol;
            x_sh   = (q == 0);
            x_ws   = ((bi / w) % 2) == 1;
            x_fr   = x_sh && ((bi % (2 * w)) == 0);
         end else begin
            x_mclk = 0; x_ck = idle_pol; x_ws = 0; x_sh = 0; x_fr = 0;
         end
         if (!en)         begin m_run = 1'b0; m_e = 0; end
         else if (!m_run) m_run = 1'b1;
         else             m_e++;
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         chk(mclk_o == x_mclk, mclk_oe ? "R1 mclk" : "R5 mclk held low", int'(mclk_o), int'(x_mclk));
         chk(ck_o == x_ck, "R6 ck level", int'(ck_o), int'(x_ck));
         chk(ws_o == x_ws, "R8 ws", int'(ws_o), int'(x_ws));
         chk(shift_stb == x_sh, "R9 shift_stb", int'(shift_stb), int'(x_sh));
         chk(frame_stb == x_fr, "R9 frame_stb", int'(frame_stb), int'(x_fr));
      end
   end

   // Frame monitor
   int cyc = 0;
   int nfr = 0, lastf = 0, firstf = 0, per = 0;
   always @(posedge clk) cyc++;
   always @(negedge clk) begin
      if (cmp_on && frame_stb) begin
         if (nfr > 0) per = cyc - lastf;
         else         firstf = cyc;
         lastf = cyc;
         nfr++;
      end
   end

   task automatic run_case(input int l, input bit od, input bit mo, input bit c32,
                           input bit pol, input int exp_per, input string tag);
      int c0;
      int guard;
      @(negedge clk);
      en = 1'b0;
      repeat (2) @(negedge clk);
      lin_div = 8'(l); odd_adj = od; mclk_oe = mo; long_ch = c32; idle_pol = pol;
      repeat (3) @(negedge clk);
      chk(ck_o == pol, "R6 idle level while disabled", int'(ck_o), int'(pol));
      chk(!shift_stb && !frame_stb && !ws_o && !mclk_o, "R10 idle outputs while disabled",
          int'({ws_o, mclk_o, shift_stb, frame_stb}), 0);
      nfr = 0; per = 0;
      c0 = cyc;
      en = 1'b1;
      guard = 0;
      while (nfr < 3 && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      chk(per == exp_per, {tag, " frame period"}, per, exp_per);
      chk(firstf - c0 == 2, "R10 start latency", firstf - c0, 2);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!mclk_o && !ck_o && !ws_o && !shift_stb && !frame_stb, "R10 reset state",
          int'({mclk_o, ck_o, ws_o, shift_stb, frame_stb}), 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      repeat (2) @(negedge clk);

      run_case(23, 1'b1, 1'b0, 1'b0, 1'b0, 32 * 47, "R2");
      run_case(11, 1'b1, 1'b0, 1'b1, 1'b1, 64 * 23, "R3");
      run_case(3,  1'b0, 1'b1, 1'b0, 1'b0, 256 * 6, "R4");
      run_case(3,  1'b0, 1'b1, 1'b1, 1'b1, 256 * 6, "R4");
      run_case(0,  1'b1, 1'b0, 1'b0, 1'b1, 32 * 5, "R7");
      run_case(1,  1'b0, 1'b1, 1'b1, 1'b0, 256 * 4, "R7");
      run_case(4,  1'b1, 1'b1, 1'b0, 1'b1, 256 * 9, "R1");

      @(negedge clk);
      en = 1'b0;
      repeat (3) @(negedge clk);
      chk(ck_o == idle_pol, "R6 final idle level", int'(ck_o), int'(idle_pol));
      chk(!ws_o && !shift_stb && !frame_stb && !mclk_o, "R10 final idle outputs",
          int'({ws_o, mclk_o, shift_stb, frame_stb}), 0);
      cmp_on = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule